// File: doc/BRIEF.md
# UART Bit-Timing Generator

This block derives every timing pulse a UART needs from the core clock. A 16-bit divisor drives a prescaler that emits one sample-clock tick per divisor clocks. An in-bit counter gathers those ticks into bit periods. It flags the last tick of each bit as a bit boundary, and it raises a sample strobe on one chosen tick for the receiver's data slicer.

Software programs the block through an 8-bit register port. The divisor bytes sit at the same addresses as the neighbouring data and interrupt-enable registers. They become visible only while the latch-access bit of the line-control register is set. A speed register picks one of three oversampling schemes:
- 16 ticks per bit;
- 4 ticks per bit;
- a programmable tick count with a programmable sample tick, for high rates or slow reference clocks.

A start-sync input lets the receiver realign the bit counter to a detected start edge.

Top module: `uart_baud_gen`

## Requirements
- R1: With speed code 0, a bit lasts 16 ticks. The bit-boundary pulse comes on the tick where the in-bit count is 15, and the sample strobe comes on the tick where it is 7. The tick-count and sample-point registers have no effect.
- R2: With speed code 2, a bit lasts 4 ticks. The bit-boundary pulse comes on in-bit count 3 and the sample strobe on in-bit count 1.
- R3: With speed code 3, a bit lasts N ticks, where the tick-count register (address 10) holds N-1 and N may be any value from 2 to 256. The sample strobe fires on the tick whose in-bit count equals the sample-point register (address 11).
- R4: Speed code 1 is reserved and times exactly like speed code 0.
- R5: The prescaler gives one tick every D clocks, where D is the 16-bit divisor. After a restart, the first tick comes in the D-th clock cycle. A divisor of 0 is treated as 1, which gives a tick every cycle.
- R6: Address 0 holds the divisor low byte and address 1 holds the divisor high byte, but only while bit 7 of the line-control register (address 3) is 1. When that bit is 0, writes to these addresses leave the divisor unchanged and cause no restart, and reads return 0.
- R7: A write to either divisor byte, or to the speed register (address 9, bits 1:0), clears the prescaler and the in-bit counter, and suppresses the tick in the write cycle.
- R8: In a cycle where start_sync is 1, there is no bit-boundary pulse and no sample strobe, and the in-bit counter is 0 in the next cycle.
- R9: After reset, the registers read as follows: line control 0x00, divisor 1 (low byte 0x01, high byte 0x00), speed 0, tick count 15 and sample point 7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| start_sync | input | 1 | Clears the in-bit counter |
| tick_o | output | 1 | Sample-clock tick |
| bit_end_o | output | 1 | Last tick of a bit |
| sample_o | output | 1 | Receiver sample strobe |

## Verification
The hardest case to reach is the one where a latched-off write to address 0 or 1 must leave the timing untouched. Reading the divisor back cannot show whether a spurious restart occurred. The bench therefore runs with a divisor of 1, so that a tick is expected in every cycle. It then checks that tick_o stays high during the ignored write, while a real divisor write in the same setting drops the tick. Start-sync is applied on the tick that would otherwise be a bit boundary, which shows both the suppression and the shifted timing that follows.

// File: rtl/uart_bt_pkg.sv
package uart_bt_pkg;
  typedef enum logic [1:0] {
    SPD_X16  = 2'd0,
    SPD_RSVD = 2'd1,
    SPD_X4   = 2'd2,
    SPD_PROG = 2'd3
  } spd_e;

  localparam int ADDR_W = 4;
  localparam logic [ADDR_W-1:0] A_DLL  = 4'd0;
  localparam logic [ADDR_W-1:0] A_DLM  = 4'd1;
  localparam logic [ADDR_W-1:0] A_LCR  = 4'd3;
  localparam logic [ADDR_W-1:0] A_SPD  = 4'd9;
  localparam logic [ADDR_W-1:0] A_SCNT = 4'd10;
  localparam logic [ADDR_W-1:0] A_SPT  = 4'd11;
endpackage

// File: rtl/uart_bt_regs.sv
module uart_bt_regs
  import uart_bt_pkg::*;
#(
  parameter int BW = 8,
  localparam int DW = 2 * BW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BW-1:0]     wdata,
  output logic [BW-1:0]     rdata,
  output logic [DW-1:0]     divisor,
  output spd_e              mode,
  output logic [BW-1:0]     scnt,
  output logic [BW-1:0]     spt,
  output logic              restart
);
  logic [BW-1:0] lcr_q, lcr_d, dll_q, dll_d, dlm_q, dlm_d;
  logic [BW-1:0] scnt_q, scnt_d, spt_q, spt_d;
  spd_e          mode_q, mode_d;
  logic          dlab;

  assign dlab = lcr_q[BW-1];

  always_comb begin
    lcr_d   = lcr_q;
    dll_d   = dll_q;
    dlm_d   = dlm_q;
    scnt_d  = scnt_q;
    spt_d   = spt_q;
    mode_d  = mode_q;
    restart = 1'b0;
    if (wr) begin
      case (addr)
        A_LCR:  lcr_d = wdata;
        A_DLL:  if (dlab) begin dll_d = wdata; restart = 1'b1; end
        A_DLM:  if (dlab) begin dlm_d = wdata; restart = 1'b1; end
        A_SPD:  begin mode_d = spd_e'(wdata[1:0]); restart = 1'b1; end
        A_SCNT: scnt_d = wdata;
        A_SPT:  spt_d = wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lcr_q  <= '0;
      dll_q  <= BW'(1);
      dlm_q  <= '0;
      mode_q <= SPD_X16;
      scnt_q <= BW'(15);
      spt_q  <= BW'(7);
    end else begin
      lcr_q  <= lcr_d;
      dll_q  <= dll_d;
      dlm_q  <= dlm_d;
      mode_q <= mode_d;
      scnt_q <= scnt_d;
      spt_q  <= spt_d;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_LCR:  rdata = lcr_q;
      A_DLL:  if (dlab) rdata = dll_q;
      A_DLM:  if (dlab) rdata = dlm_q;
      A_SPD:  rdata = BW'(mode_q);
      A_SCNT: rdata = scnt_q;
      A_SPT:  rdata = spt_q;
      default: rdata = '0;
    endcase
  end

  assign divisor = {dlm_q, dll_q};
  assign mode    = mode_q;
  assign scnt    = scnt_q;
  assign spt     = spt_q;

  // R6: with the latch closed, the shared addresses cannot alter the divisor
  a_r6_latch_closed: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !dlab && (addr == A_DLL || addr == A_DLM)) |=> $stable(divisor));
endmodule

// File: rtl/uart_bt_prescale.sv
module uart_bt_prescale #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] divisor,
  input  logic          restart,
  output logic          tick
);
  logic [DW-1:0] pcnt_q, pcnt_d, lim;
  logic          wrap;

  assign lim  = (divisor == '0) ? '0 : divisor - DW'(1);
  assign wrap = (pcnt_q >= lim);
  assign tick = wrap && !restart;

  always_comb begin
    if (restart || wrap) pcnt_d = '0;
    else                 pcnt_d = pcnt_q + DW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pcnt_q <= '0;
    else        pcnt_q <= pcnt_d;
  end

  // R5: the count never runs past the divisor limit
  a_r5_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    pcnt_q <= lim);
endmodule

// File: rtl/uart_bt_bitcnt.sv
module uart_bt_bitcnt #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          restart,
  input  logic          sync,
  input  logic [CW-1:0] last,
  input  logic [CW-1:0] spt,
  output logic          bit_end,
  output logic          sample
);
  logic [CW-1:0] bcnt_q, bcnt_d;
  logic          at_last;

  assign at_last = (bcnt_q >= last);
  assign bit_end = tick && at_last && !sync;
  assign sample  = tick && (bcnt_q == spt) && !sync;

  always_comb begin
    bcnt_d = bcnt_q;
    if (restart || sync) bcnt_d = '0;
    else if (tick)       bcnt_d = at_last ? '0 : bcnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bcnt_q <= '0;
    else        bcnt_q <= bcnt_d;
  end

  // R8: start sync realigns the bit counter
  a_r8_sync_clears: assert property (@(posedge clk) disable iff (!rst_n)
    sync |=> (bcnt_q == '0));
endmodule

// File: rtl/uart_baud_gen.sv
module uart_baud_gen
  import uart_bt_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int DIV_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  input  logic              start_sync,
  output logic              tick_o,
  output logic              bit_end_o,
  output logic              sample_o
);
  logic              rst_meta, rst_s;
  logic [DIV_W-1:0]  divisor;
  spd_e              mode;
  logic [BYTE_W-1:0] scnt, spt, last_sel, spt_sel;
  logic              restart;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_s    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_s    <= rst_meta;
    end
  end

  uart_bt_regs #(.BW(BYTE_W)) u_regs (
    .clk(clk), .rst_n(rst_s), .wr(bus_wr), .addr(bus_addr),
    .wdata(bus_wdata), .rdata(bus_rdata), .divisor(divisor), .mode(mode),
    .scnt(scnt), .spt(spt), .restart(restart)
  );

  always_comb begin
    case (mode)
      SPD_X4:   begin last_sel = BYTE_W'(3);  spt_sel = BYTE_W'(1); end
      SPD_PROG: begin last_sel = scnt;        spt_sel = spt;        end
      default:  begin last_sel = BYTE_W'(15); spt_sel = BYTE_W'(7); end
    endcase
  end

  uart_bt_prescale #(.DW(DIV_W)) u_pre (
    .clk(clk), .rst_n(rst_s), .divisor(divisor), .restart(restart),
    .tick(tick_o)
  );

  uart_bt_bitcnt #(.CW(BYTE_W)) u_bit (
    .clk(clk), .rst_n(rst_s), .tick(tick_o), .restart(restart),
    .sync(start_sync), .last(last_sel), .spt(spt_sel),
    .bit_end(bit_end_o), .sample(sample_o)
  );

  // R7: a restart leaves both counters at zero
  a_r7_restart_clears: assert property (@(posedge clk) disable iff (!rst_s)
    restart |=> (u_pre.pcnt_q == '0 && u_bit.bcnt_q == '0));
  // R1: boundary and sample strobes only ride on ticks
  a_r1_strobes_on_tick: assert property (@(posedge clk) disable iff (!rst_s)
    (bit_end_o || sample_o) |-> tick_o);
  // R7: no tick while a restart is taking effect
  a_r7_no_tick_on_restart: assert property (@(posedge clk) disable iff (!rst_s)
    restart |-> !tick_o);
endmodule

// File: tb/uart_baud_gen_test.sv
module uart_baud_gen_test;
  import uart_bt_pkg::*;

  logic       clk, rst_n, bus_wr, start_sync;
  logic [3:0] bus_addr;
  logic [7:0] bus_wdata, bus_rdata;
  logic       tick_o, bit_end_o, sample_o;
  int checks = 0;
  int errors = 0;

  uart_baud_gen uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .start_sync(start_sync),
    .tick_o(tick_o), .bit_end_o(bit_end_o), .sample_o(sample_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  localparam int NV = 8;
  localparam int V_MODE [NV] = '{0, 2, 3, 1, 3, 0, 3, 3};
  localparam int V_DIV  [NV] = '{3, 5, 2, 1, 1, 258, 0, 4};
  localparam int V_SC   [NV] = '{2, 0, 9, 0, 255, 0, 3, 1};
  localparam int V_SP   [NV] = '{0, 3, 4, 0, 127, 0, 1, 0};
  localparam int V_TICK [NV] = '{2, 4, 1, 0, 0, 257, 0, 3};
  localparam int V_SMP  [NV] = '{23, 9, 9, 7, 127, 2063, 1, 3};
  localparam int V_END  [NV] = '{47, 19, 19, 15, 255, 4127, 3, 7};
  localparam int V_END2 [NV] = '{95, 39, 39, 31, 511, 8255, 7, 15};
  localparam string V_TAG [NV] = '{"R1", "R2", "R3", "R4", "R3", "R5", "R5", "R3"};

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
  endtask

  task automatic rd(input logic [3:0] a, output int v);
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = a;
    #1 v = int'(bus_rdata);
  endtask

  task automatic cfg(input int m, input int dv, input int sc, input int sp);
    wr(A_SCNT, 8'(sc));
    wr(A_SPT, 8'(sp));
    wr(A_LCR, 8'h83);
    wr(A_DLL, 8'(dv));
    wr(A_DLM, 8'(dv >> 8));
    wr(A_LCR, 8'h03);
    wr(A_SPD, 8'(m));
  endtask

  task automatic measure(input int win, output int t0, output int s0,
                         output int e0, output int e1);
    t0 = -1; s0 = -1; e0 = -1; e1 = -1;
    @(negedge clk);
    bus_wr = 1'b0;
    for (int c = 0; c < win; c++) begin
      #1;
      if (tick_o && t0 < 0) t0 = c;
      if (sample_o && s0 < 0) s0 = c;
      if (bit_end_o) begin
        if (e0 < 0) e0 = c;
        else if (e1 < 0) e1 = c;
      end
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int v, t0, s0, e0, e1;
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    start_sync = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);

    for (int i = 0; i < NV; i++) begin
      cfg(V_MODE[i], V_DIV[i], V_SC[i], V_SP[i]);
      measure(V_END2[i] + 5, t0, s0, e0, e1);
      chk({V_TAG[i], "/R7 first tick"}, t0, V_TICK[i]);
      chk({V_TAG[i], " first sample"}, s0, V_SMP[i]);
      chk({V_TAG[i], " first bit end"}, e0, V_END[i]);
      chk({V_TAG[i], " second bit end"}, e1, V_END2[i]);
    end

    // R9: reset values
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);
    rd(A_LCR, v);  chk("R9 lcr", v, 0);
    rd(A_SPD, v);  chk("R9 speed", v, 0);
    rd(A_SCNT, v); chk("R9 tick count", v, 15);
    rd(A_SPT, v);  chk("R9 sample point", v, 7);
    rd(A_DLL, v);  chk("R6 dll hidden", v, 0);
    wr(A_LCR, 8'h80);
    rd(A_DLL, v);  chk("R9 dll", v, 1);
    rd(A_DLM, v);  chk("R9 dlm", v, 0);

    // R6: latch closed, writes ignored and no restart (divisor 1 -> tick every cycle)
    wr(A_LCR, 8'h03);
    wr(A_DLL, 8'hAA);
    #1 chk("R6 tick during ignored write", int'(tick_o), 1);
    wr(A_DLM, 8'h55);
    #1 chk("R6 tick during ignored high write", int'(tick_o), 1);
    wr(A_LCR, 8'h83);
    rd(A_DLL, v);  chk("R6 dll kept", v, 1);
    rd(A_DLM, v);  chk("R6 dlm kept", v, 0);

    // R7: a real divisor write drops the tick in its cycle
    wr(A_DLL, 8'h01);
    #1 chk("R7 tick suppressed on write", int'(tick_o), 0);
    wr(A_LCR, 8'h03);

    // R8: start sync in mode 2, divisor 1, on the would-be boundary tick
    cfg(2, 1, 0, 0);
    @(negedge clk);
    bus_wr = 1'b0;
    for (int c = 0; c < 9; c++) begin
      start_sync = (c == 3);
      #1;
      chk($sformatf("R8 bit end c%0d", c), int'(bit_end_o), (c == 7) ? 1 : 0);
      chk($sformatf("R8 sample c%0d", c), int'(sample_o),
          (c == 1 || c == 5) ? 1 : 0);
      @(negedge clk);
    end
    start_sync = 1'b0;

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule